// File: doc/BRIEF.md
# Burst Preamble and Scrambler Framer

This block assembles the serial bit stream of one transmit burst. A burst opens on the first bit strobe that finds transmit-enable high while the framer is idle. The framer first sends a preamble of 0 to 96 bits, taken from a configuration vector. These bits are sent without any scrambling. It then sends the payload bits, each XORed with a pseudo-random sequence from an additive scrambler. The scrambler is either a 6-stage or a 15-stage LFSR, chosen by a mode code. Its seed is reloaded at the start of every burst.

Payload bits arrive on every strobe while transmit-enable is high. That includes the very first strobe, even though preamble bits are being sent at that time. An internal delay line therefore holds the payload back by exactly the preamble length, so that it follows directly behind the last preamble bit. When transmit-enable drops, the framer keeps going for as many further strobes as there are preamble bits. This drains the delayed payload, and then the framer returns to idle.

The controller has four states. `ST_IDLE` waits for a burst. `ST_PRE` sends preamble bits while transmit-enable is high. `ST_PAY` sends scrambled payload while transmit-enable is high. `ST_DRAIN` empties the delay line after transmit-enable has dropped. The transitions are:
- start: `ST_IDLE` goes to `ST_PRE` when the length is above 1, and to `ST_PAY` otherwise.
- pre_done: `ST_PRE` goes to `ST_PAY` on the strobe that sends the last preamble bit.
- close: `ST_PRE` or `ST_PAY` goes to `ST_DRAIN` on a strobe with transmit-enable low, when the length is above 1.
- close_short: the same strobe goes straight to `ST_IDLE` when the length is 0 or 1.
- drain_done: `ST_DRAIN` goes to `ST_IDLE` on its last strobe.

Top module: `burst_framer`

## Requirements
- R1: After reset, `out_valid` is low, and strobes that arrive with `tx_en` low while the framer is idle produce no output.
- R2: A burst starts on a `bit_stb` cycle with `tx_en` high in the idle state. Each strobe of a burst produces at most one output bit, and that bit appears with `out_valid` high in the clock cycle right after the strobe.
- R3: The first L output bits of a burst are preamble bits, with L = `cfg_pre_len`. They are sent from `cfg_pre_data[95]` downward with `out_is_pre` high, and they are never scrambled.
- R4: With L = 0, the first output bit of a burst is already payload bit 0, scrambled.
- R5: Mode code 2'b00 selects the 6-stage scrambler (x^6 + x^5 + 1). Its seed is `cfg_seed_hi[6:1]`. Each payload bit is XORed with s[5]^s[4], and the state then shifts left by one with that value entering bit 0.
- R6: Mode code 2'b01 selects the 15-stage scrambler (x^15 + x^14 + 1). Its seed is {`cfg_seed_hi`, `cfg_seed_lo`}. Each payload bit is XORed with s[14]^s[13], and the state then shifts left with that value entering bit 0.
- R7: Mode codes 2'b10 and 2'b11 send the payload unchanged.
- R8: The scrambler is reloaded from the seed at every burst start, so identical bursts give identical output.
- R9: A burst with P strobes at `tx_en` high sends exactly L + P bits. Payload bit k appears at position L + k, including when P < L. The remaining bits go out on the strobes that follow the fall of `tx_en`.
- R10: The scrambler advances only on payload bits. The first payload bit of a burst uses the seed state, whatever the value of L.
- R11: Length, preamble content, mode and seed are captured at burst start. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle bit-time strobe |
| tx_en | input | 1 | Transmit enable framing the payload |
| pay_bit | input | 1 | Serial payload bit, sampled on strobes |
| cfg_pre_len | input | 7 | Preamble length L; values above 96 act as 96 |
| cfg_pre_data | input | 96 | Preamble content, bit 95 sent first |
| cfg_scr_mode | input | 2 | Scrambler mode code |
| cfg_seed_lo | input | 8 | Low seed byte (15-stage mode) |
| cfg_seed_hi | input | 7 | Upper seed field |
| out_valid | output | 1 | Output bit valid |
| out_bit | output | 1 | Framed serial bit |
| out_is_pre | output | 1 | High while the bit is a preamble bit |

## Verification
Two functions can fall on the same strobe. The first is sending the last preamble bit. The second is either the fall of `tx_en` or the very first scrambler step. With L = 0, the seed load and the first scramble happen on the same start strobe. Bursts shorter than their preamble drop `tx_en` while preamble bits are still pending. Both cases are provoked directly. A bit-exact scoreboard judges them: it expects all L preamble bits first, then every payload bit in order with a scrambler model started from the seed.

// File: rtl/bframe_pkg.sv
package bframe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_PAY   = 2'd2,
        ST_DRAIN = 2'd3
    } fr_state_t;

    localparam logic [1:0] SCR_M6  = 2'b00;
    localparam logic [1:0] SCR_M15 = 2'b01;
    localparam int LFSR_W = 15;
endpackage

// File: rtl/bframe_scrambler.sv
module bframe_scrambler
    import bframe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [1:0]        mode_i,
    input  logic [LFSR_W-1:0] seed_i,
    output logic              prbs_o,
    output logic [LFSR_W-1:0] state_o
);
    logic [LFSR_W-1:0] st_q;
    logic [LFSR_W-1:0] cur;
    logic [LFSR_W-1:0] nxt;
    logic              fb;

    // current state is the seed on the load strobe so the first bit can use it
    always_comb begin
        cur = load_i ? seed_i : st_q;
        unique case (mode_i)
            SCR_M6: begin
                fb  = cur[5] ^ cur[4];
                nxt = {{(LFSR_W-6){1'b0}}, cur[4:0], fb};
            end
            SCR_M15: begin
                fb  = cur[14] ^ cur[13];
                nxt = {cur[13:0], fb};
            end
            default: begin
                fb  = 1'b0;
                nxt = cur;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (load_i || step_i) begin
            st_q <= step_i ? nxt : cur;
        end
    end

    assign prbs_o  = fb;
    assign state_o = st_q;
endmodule

// File: rtl/bframe_preamble.sv
module bframe_preamble #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] data_i,
    output logic         bit_o
);
    logic [W-1:0] sr_q;
    logic [W-1:0] cur;

    assign cur   = load_i ? data_i : sr_q;
    assign bit_o = cur[W-1];

    // reset clears the held preamble content
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i || shift_i) begin
            sr_q <= shift_i ? {cur[W-2:0], 1'b0} : cur;
        end
    end
endmodule

// File: rtl/bframe_delay.sv
module bframe_delay #(
    parameter int DEPTH = 96,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             din_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             dout_o
);
    logic [DEPTH-1:0] dl_q;
    logic [LEN_W-1:0] idx;

    assign idx    = len_i - 1'b1;
    assign dout_o = (len_i == '0) ? din_i : dl_q[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_q <= '0;
        end else if (shift_i) begin
            dl_q <= {dl_q[DEPTH-2:0], din_i};
        end
    end
endmodule

// File: rtl/burst_framer.sv
module burst_framer
    import bframe_pkg::*;
#(
    parameter int PRE_MAX = 96,
    parameter int LEN_W   = $clog2(PRE_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_stb,
    input  logic               tx_en,
    input  logic               pay_bit,
    input  logic [LEN_W-1:0]   cfg_pre_len,
    input  logic [PRE_MAX-1:0] cfg_pre_data,
    input  logic [1:0]         cfg_scr_mode,
    input  logic [7:0]         cfg_seed_lo,
    input  logic [6:0]         cfg_seed_hi,
    output logic               out_valid,
    output logic               out_bit,
    output logic               out_is_pre
);
    localparam logic [LEN_W-1:0] PRE_MAX_L = LEN_W'(PRE_MAX);
    localparam logic [LEN_W-1:0] ONE_L     = LEN_W'(1);

    fr_state_t         state_q, state_d;
    logic [LEN_W-1:0]  len_q, left_q, drain_q;
    logic [1:0]        mode_q;

    logic [LEN_W-1:0]  len_in, burst_len, cur_left;
    logic [1:0]        cur_mode;
    logic [LFSR_W-1:0] seed_vec, scr_state;
    logic              start, active, live, emit, emit_pre, emit_pay;
    logic              dly_din, dly_bit, pre_bit, prbs;

    always_comb begin
        len_in    = (cfg_pre_len > PRE_MAX_L) ? PRE_MAX_L : cfg_pre_len;
        start     = bit_stb && tx_en && (state_q == ST_IDLE);
        active    = bit_stb && ((state_q != ST_IDLE) || tx_en);
        live      = (state_q == ST_PRE) || (state_q == ST_PAY);
        burst_len = start ? len_in : len_q;
        cur_left  = start ? len_in : left_q;
        cur_mode  = start ? cfg_scr_mode : mode_q;
        seed_vec  = (cfg_scr_mode == SCR_M6) ? {{(LFSR_W-6){1'b0}}, cfg_seed_hi[6:1]}
                                             : {cfg_seed_hi, cfg_seed_lo};
        emit      = active && !(live && !tx_en && (len_q == '0));
        emit_pre  = emit && (cur_left != '0);
        emit_pay  = emit && (cur_left == '0);
        dly_din   = (tx_en && (state_q != ST_DRAIN)) ? pay_bit : 1'b0;
    end

    bframe_preamble #(.W(PRE_MAX)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .shift_i (emit_pre),
        .data_i  (cfg_pre_data),
        .bit_o   (pre_bit)
    );

    bframe_scrambler u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .step_i  (emit_pay),
        .mode_i  (cur_mode),
        .seed_i  (seed_vec),
        .prbs_o  (prbs),
        .state_o (scr_state)
    );

    bframe_delay #(.DEPTH(PRE_MAX), .LEN_W(LEN_W)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (active),
        .din_i   (dly_din),
        .len_i   (burst_len),
        .dout_o  (dly_bit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (len_in > ONE_L) ? ST_PRE : ST_PAY;
            end
            ST_PRE: begin
                if (bit_stb) begin
                    if (!tx_en)                state_d = (len_q > ONE_L) ? ST_DRAIN : ST_IDLE;
                    else if (left_q == ONE_L)  state_d = ST_PAY;
                end
            end
            ST_PAY: begin
                if (bit_stb && !tx_en)         state_d = (len_q > ONE_L) ? ST_DRAIN : ST_IDLE;
            end
            ST_DRAIN: begin
                if (bit_stb && drain_q == ONE_L) state_d = ST_IDLE;
            end
        endcase
    end

    // state register and burst counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            left_q  <= '0;
            drain_q <= '0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                len_q  <= len_in;
                mode_q <= cfg_scr_mode;
            end
            if (emit_pre)   left_q <= cur_left - 1'b1;
            else if (start) left_q <= cur_left;
            if (bit_stb && live && !tx_en)         drain_q <= len_q - 1'b1;
            else if (bit_stb && state_q == ST_DRAIN) drain_q <= drain_q - 1'b1;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_bit    <= 1'b0;
            out_is_pre <= 1'b0;
        end else begin
            out_valid  <= emit;
            out_is_pre <= emit_pre;
            out_bit    <= emit ? (emit_pre ? pre_bit : (dly_bit ^ prbs)) : 1'b0;
        end
    end
endmodule

// File: rtl/bframe_checker.sv
module bframe_checker
    import bframe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_stb,
    input logic              tx_en,
    input logic              out_valid,
    input logic              out_is_pre,
    input fr_state_t         state_q,
    input logic              emit_pre,
    input logic              emit_pay,
    input logic              start,
    input logic [LFSR_W-1:0] scr_state
);
    AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bit_stb)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tx_en) |=> !out_valid); // R1
    AST_PRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAY) |-> !emit_pre); // R3
    AST_PRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_pre |-> out_valid); // R3
    AST_SCR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(start || emit_pay) |=> $stable(scr_state)); // R10
endmodule

bind burst_framer bframe_checker chk_i (.*);

// File: tb/burst_framer_tb_top.sv
module burst_framer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0;
    logic        tx_en = 1'b0;
    logic        pay_bit = 1'b0;
    logic [6:0]  cfg_pre_len = '0;
    logic [95:0] cfg_pre_data = '0;
    logic [1:0]  cfg_scr_mode = '0;
    logic [7:0]  cfg_seed_lo = '0;
    logic [6:0]  cfg_seed_hi = '0;
    logic        out_valid, out_bit, out_is_pre;

    typedef struct {
        logic  b;
        logic  p;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    int spurious = 0;

    always #2 clk = ~clk;

    burst_framer dut_i (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_en(tx_en), .pay_bit(pay_bit),
        .cfg_pre_len(cfg_pre_len), .cfg_pre_data(cfg_pre_data), .cfg_scr_mode(cfg_scr_mode),
        .cfg_seed_lo(cfg_seed_lo), .cfg_seed_hi(cfg_seed_hi),
        .out_valid(out_valid), .out_bit(out_bit), .out_is_pre(out_is_pre)
    );

    // monitor: compares each produced bit with the scoreboard head
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && out_valid) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                spurious++;
                $display("FAIL R1: unexpected output bit=%b pre=%b, expected none", out_bit, out_is_pre);
            end else begin
                e = q.pop_front();
                if (out_bit !== e.b || out_is_pre !== e.p) begin
                    fails++;
                    $display("FAIL %s: bit=%b pre=%b expected bit=%b pre=%b",
                             e.tag, out_bit, out_is_pre, e.b, e.p);
                end
            end
        end
    end

    task automatic stb(input logic en, input logic b);
        @(negedge clk);
        tx_en = en; pay_bit = b; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic burst(input int len, input logic [95:0] pre, input logic [1:0] mode,
                         input logic [6:0] shi, input logic [7:0] slo, input int n,
                         input logic [255:0] pay, input string tag, input bit chg);
        logic [14:0] s;
        exp_t e;
        cfg_pre_len = 7'(len); cfg_pre_data = pre; cfg_scr_mode = mode;
        cfg_seed_hi = shi; cfg_seed_lo = slo;
        s = (mode == 2'b00) ? {9'b0, shi[6:1]} : {shi, slo};
        for (int i = 0; i < len + n; i++) begin
            if (i < len) begin
                e.b = pre[95-i]; e.p = 1'b1;
            end else begin
                logic fb;
                fb = mode[1] ? 1'b0 : ((mode == 2'b00) ? (s[5] ^ s[4]) : (s[14] ^ s[13]));
                e.b = pay[i-len] ^ fb; e.p = 1'b0;
                if (mode == 2'b00) s = {9'b0, s[4:0], fb};
                else               s = {s[13:0], fb};
            end
            e.tag = tag;
            q.push_back(e);
        end
        for (int k = 0; k < n; k++) begin
            stb(1'b1, pay[k]);
            if (chg && k == 0) begin
                cfg_pre_len = 7'd3; cfg_pre_data = ~pre; cfg_scr_mode = mode ^ 2'b01;
                cfg_seed_hi = ~shi; cfg_seed_lo = ~slo;
            end
        end
        for (int k = 0; k < len + 2; k++) stb(1'b0, 1'($urandom));
        repeat (2) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R9: %0d bits missing, expected 0 (burst %s)", q.size(), tag);
            q.delete();
        end
    endtask

    function automatic logic [255:0] rnd_vec();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [255:0] pv;
        logic [95:0]  pr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid=%b after reset, expected 0", out_valid);
        end
        // R1: idle strobes with tx_en low
        for (int k = 0; k < 4; k++) stb(1'b0, 1'b1);
        checks++;
        if (spurious != 0) begin
            fails++;
            $display("FAIL R1: %0d idle outputs, expected 0", spurious);
        end

        pr = {$urandom, $urandom, $urandom};
        burst(16, pr, 2'b01, 7'h35, 8'hA7, 40, rnd_vec(), "R2/R3/R6", 1'b0);
        burst(0, pr, 2'b00, 7'h5B, 8'h00, 30, rnd_vec(), "R4/R5/R10", 1'b0);
        burst(96, {$urandom, $urandom, $urandom}, 2'b01, 7'h01, 8'h00, 20, rnd_vec(), "R9/R10", 1'b0);
        burst(8, pr, 2'b10, 7'h7F, 8'hFF, 24, rnd_vec(), "R7", 1'b0);
        burst(8, pr, 2'b11, 7'h7F, 8'hFF, 24, rnd_vec(), "R7", 1'b0);
        pv = rnd_vec();
        burst(5, pr, 2'b01, 7'h2C, 8'h91, 32, pv, "R8", 1'b0);
        burst(5, pr, 2'b01, 7'h2C, 8'h91, 32, pv, "R8", 1'b0);
        burst(12, pr, 2'b00, 7'h6A, 8'h10, 28, rnd_vec(), "R11", 1'b0 | 1'b1);
        burst(1, pr, 2'b00, 7'h44, 8'h00, 1, rnd_vec(), "R9", 1'b0);
        burst(2, pr, 2'b01, 7'h12, 8'h34, 1, rnd_vec(), "R9", 1'b0);
        burst(1, pr, 2'b01, 7'h00, 8'h01, 9, rnd_vec(), "R3/R10", 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule